// File: doc/BRIEF.md
# Bus Ownership Handoff Controller

This block sits between a central bus arbiter and the host bridge, which owns the shared bus whenever nobody else does. When the arbiter reports that an external bus master or a DMA channel wants the bus, the controller raises a hold request toward the bridge. While the hold acknowledge is outstanding it keeps following the arbiter, so the pending winner may still change. The winner is frozen on the clock edge at which the acknowledge is sampled.

A non-bridge winner is never acknowledged until the bridge has emptied its posted buffers. The two sides share one active-high flush line. The controller drives the flush line high for exactly one cycle and then releases it. The bridge holds it high until its buffers are empty, drives it low, and releases it. The controller then takes the line back, driving it inactive. The grant strobe for the frozen master or DMA channel follows one cycle later. The bridge takes the bus back when the owner finishes or when the bridge raises its own bus request (preemption). In either case the hold request is dropped.

States: ST_IDLE (bridge owns the bus), ST_HOLD_REQ (hold raised, winner live), ST_FLUSH_PULSE (controller drives flush high), ST_FLUSH_WAIT (line released, bridge flushing), ST_FLUSH_RESUME (controller drives flush low again), ST_GRANT (acknowledge strobe active), ST_RELEASE (hold dropped, waiting for the acknowledge to fall). Transitions are as follows:
- IDLE goes to HOLD_REQ on an external request.
- HOLD_REQ goes to FLUSH_PULSE on an acknowledge with an external winner, or to RELEASE on an acknowledge with a bridge winner.
- FLUSH_PULSE always goes to FLUSH_WAIT.
- FLUSH_WAIT goes to FLUSH_RESUME when it samples flush low.
- FLUSH_RESUME always goes to GRANT.
- GRANT goes to RELEASE on a bridge request or when the request is withdrawn.
- RELEASE goes to IDLE once the acknowledge is low.

Top module: `bus_handoff_ctrl`

## Requirements
- R1: In reset and right after it, hold is low, both acknowledge vectors are zero, and the controller drives the flush line (output enable 1) with value 0.
- R2: An external request means arb_valid_i=1 with arb_kind_i equal to 1 (master) or 2 (DMA); the values 0 and 3 denote the bridge. When such a request is sampled in ST_IDLE, hold_o is high in the next cycle.
- R3: While hold is high and the acknowledge has not been sampled, the winner follows arb_kind_i and arb_id_i. The winner granted is the one present on the edge where hold_ack_i is first sampled high.
- R4: If the frozen winner is the bridge, hold_o falls in the next cycle. No flush pulse and no acknowledge occur.
- R5: After an external winner is frozen, the next cycle has flush output enable 1 and value 1 for exactly one cycle, followed by output enable 0.
- R6: While released, the controller keeps output enable 0 until it samples the flush line low. In the following cycle it drives the line with value 0, and no acknowledge is ever active unless the controller drives flush low.
- R7: The acknowledge rises one cycle after the controller resumes driving flush. It is one-hot: bit arb_id of mst_ack_o for kind 1, bit arb_id of dma_ack_o for kind 2. While it is active, hold and the hold acknowledge are both high.
- R8: The acknowledge stays steady while the request stays valid. When arb_valid_i falls in ST_GRANT, the acknowledge and hold are both low in the next cycle.
- R9: A bridge request sampled in ST_GRANT preempts the owner: the acknowledge and hold are both low in the next cycle.
- R10: After hold falls, no new hold is raised while hold_ack_i is still high, even with an external request pending.
- R11: The controller never enables its flush driver in a cycle in which the bridge drives the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arb_valid_i | input | 1 | Arbiter reports a pending requester |
| arb_kind_i | input | 2 | Requester class: 0/3 bridge, 1 master, 2 DMA |
| arb_id_i | input | ID_W | Index of the master or DMA channel |
| bridge_req_i | input | 1 | Bridge asks for the bus back |
| hold_o | output | 1 | Hold request to the bridge |
| hold_ack_i | input | 1 | Hold acknowledge from the bridge |
| flush_oe_o | output | 1 | Controller enables its flush driver |
| flush_out_o | output | 1 | Value driven on the flush line |
| flush_in_i | input | 1 | Sampled level of the shared flush line |
| mst_ack_o | output | NUM_MST | One-hot master acknowledge |
| dma_ack_o | output | NUM_DMA | One-hot DMA channel acknowledge |

## Verification
On every cycle, the assertions check the following: the one-cycle flush pulse, the resumed drive after flush is sampled low, the rule that an acknowledge only appears with hold, hold acknowledge and a resumed low flush, one-hot acknowledges, and the hold drop after a bridge winner, a preemption or a withdrawn request. Only the bench scenarios can show that the granted index is the one present on the freezing edge rather than an earlier pending one, and that the acknowledge arrives exactly one cycle after the bridge releases the line for random flush lengths. The same holds for the absence of driver overlap on the shared line, because only the bench models the bridge's driver.

// File: rtl/bho_pkg.sv
package bho_pkg;

    typedef enum logic [1:0] {
        WK_BRIDGE = 2'd0,
        WK_MASTER = 2'd1,
        WK_DMA    = 2'd2
    } win_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE         = 3'd0,
        ST_HOLD_REQ     = 3'd1,
        ST_FLUSH_PULSE  = 3'd2,
        ST_FLUSH_WAIT   = 3'd3,
        ST_FLUSH_RESUME = 3'd4,
        ST_GRANT        = 3'd5,
        ST_RELEASE      = 3'd6
    } ho_state_e;

    // Values 0 and 3, or no valid request, mean the bridge itself.
    function automatic win_kind_e decode_kind(input logic valid, input logic [1:0] kind);
        if (!valid) return WK_BRIDGE;
        case (kind)
            2'd1:    return WK_MASTER;
            2'd2:    return WK_DMA;
            default: return WK_BRIDGE;
        endcase
    endfunction

endpackage

// File: rtl/handoff_fsm.sv
module handoff_fsm
    import bho_pkg::*;
#(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  win_kind_e       live_kind_i,
    input  logic [ID_W-1:0] live_id_i,
    input  logic            bridge_req_i,
    input  logic            hold_ack_i,
    input  logic            flush_in_i,
    output ho_state_e       state_o,
    output logic            hold_o,
    output win_kind_e       win_kind_o,
    output logic [ID_W-1:0] win_id_o
);

    ho_state_e       state_q, state_d;
    win_kind_e       win_kind_q;
    logic [ID_W-1:0] win_id_q;
    logic            ext_req;

    assign ext_req = (live_kind_i != WK_BRIDGE);

    // State register and winner freeze
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            win_kind_q <= WK_BRIDGE;
            win_id_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_HOLD_REQ && hold_ack_i) begin
                win_kind_q <= live_kind_i;
                win_id_q   <= live_id_i;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:         if (ext_req) state_d = ST_HOLD_REQ;
            ST_HOLD_REQ:     if (hold_ack_i) state_d = ext_req ? ST_FLUSH_PULSE : ST_RELEASE;
            ST_FLUSH_PULSE:  state_d = ST_FLUSH_WAIT;
            ST_FLUSH_WAIT:   if (!flush_in_i) state_d = ST_FLUSH_RESUME;
            ST_FLUSH_RESUME: state_d = ST_GRANT;
            ST_GRANT:        if (bridge_req_i || !ext_req) state_d = ST_RELEASE;
            ST_RELEASE:      if (!hold_ack_i) state_d = ST_IDLE;
            default:         state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_HOLD_REQ, ST_FLUSH_PULSE, ST_FLUSH_WAIT,
            ST_FLUSH_RESUME, ST_GRANT: hold_o = 1'b1;
            default:                   hold_o = 1'b0;
        endcase
    end

    assign state_o    = state_q;
    assign win_kind_o = win_kind_q;
    assign win_id_o   = win_id_q;

    p_hold_on_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ext_req) |=> hold_o);

    p_bridge_win_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD_REQ && hold_ack_i && !ext_req) |=> !hold_o);

    p_preempt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRANT && bridge_req_i) |=> !hold_o);

    p_release_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELEASE && hold_ack_i) |=> !hold_o);

endmodule

// File: rtl/flush_drv.sv
module flush_drv
    import bho_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ho_state_e state_i,
    output logic      flush_oe_o,
    output logic      flush_out_o
);

    always_comb begin
        flush_oe_o  = 1'b1;
        flush_out_o = 1'b0;
        unique case (state_i)
            ST_FLUSH_PULSE: flush_out_o = 1'b1;
            ST_FLUSH_WAIT:  flush_oe_o  = 1'b0;
            default:        ;
        endcase
    end

    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_oe_o && flush_out_o) |=> !flush_oe_o);

endmodule

// File: rtl/ack_dec.sv
module ack_dec
    import bho_pkg::*;
#(
    parameter int NUM_MST = 8,
    parameter int NUM_DMA = 8,
    parameter int ID_W    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               grant_i,
    input  win_kind_e          kind_i,
    input  logic [ID_W-1:0]    id_i,
    output logic [NUM_MST-1:0] mst_ack_o,
    output logic [NUM_DMA-1:0] dma_ack_o
);

    for (genvar i = 0; i < NUM_MST; i++) begin : g_mst
        assign mst_ack_o[i] = grant_i && (kind_i == WK_MASTER) && (id_i == ID_W'(i));
    end

    for (genvar j = 0; j < NUM_DMA; j++) begin : g_dma
        assign dma_ack_o[j] = grant_i && (kind_i == WK_DMA) && (id_i == ID_W'(j));
    end

    p_ack_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mst_ack_o, dma_ack_o}));

endmodule

// File: rtl/bus_handoff_ctrl.sv
module bus_handoff_ctrl
    import bho_pkg::*;
#(
    parameter int NUM_MST = 8,
    parameter int NUM_DMA = 8,
    parameter int ID_W    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arb_valid_i,
    input  logic [1:0]         arb_kind_i,
    input  logic [ID_W-1:0]    arb_id_i,
    input  logic               bridge_req_i,
    output logic               hold_o,
    input  logic               hold_ack_i,
    output logic               flush_oe_o,
    output logic               flush_out_o,
    input  logic               flush_in_i,
    output logic [NUM_MST-1:0] mst_ack_o,
    output logic [NUM_DMA-1:0] dma_ack_o
);

    ho_state_e       state;
    win_kind_e       live_kind;
    win_kind_e       win_kind;
    logic [ID_W-1:0] win_id;
    logic            any_ack;

    assign live_kind = decode_kind(arb_valid_i, arb_kind_i);

    handoff_fsm #(.ID_W(ID_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .live_kind_i  (live_kind),
        .live_id_i    (arb_id_i),
        .bridge_req_i (bridge_req_i),
        .hold_ack_i   (hold_ack_i),
        .flush_in_i   (flush_in_i),
        .state_o      (state),
        .hold_o       (hold_o),
        .win_kind_o   (win_kind),
        .win_id_o     (win_id)
    );

    flush_drv u_flush (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (state),
        .flush_oe_o  (flush_oe_o),
        .flush_out_o (flush_out_o)
    );

    ack_dec #(.NUM_MST(NUM_MST), .NUM_DMA(NUM_DMA), .ID_W(ID_W)) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant_i   (state == ST_GRANT),
        .kind_i    (win_kind),
        .id_i      (win_id),
        .mst_ack_o (mst_ack_o),
        .dma_ack_o (dma_ack_o)
    );

    assign any_ack = (|mst_ack_o) || (|dma_ack_o);

    p_resume_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_oe_o && !flush_in_i) |=> (flush_oe_o && !flush_out_o));

    p_ack_after_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any_ack |-> (flush_oe_o && !flush_out_o));

    p_ack_needs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any_ack |-> (hold_o && hold_ack_i));

    p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (any_ack && !arb_valid_i) |=> (!any_ack && !hold_o));

endmodule

// File: tb/bus_handoff_ctrl_bench.sv
module bus_handoff_ctrl_bench;

    localparam int NUM_MST = 8;
    localparam int NUM_DMA = 8;
    localparam int ID_W    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arb_valid = 1'b0;
    logic [1:0] arb_kind = 2'd0;
    logic [ID_W-1:0] arb_id = '0;
    logic bridge_req = 1'b0;
    logic hold_ack = 1'b0;
    logic hold, flush_oe, flush_out, flush_line;
    logic [NUM_MST-1:0] mst_ack;
    logic [NUM_DMA-1:0] dma_ack;

    // bridge-side flush driver model
    logic br_oe = 1'b0;
    logic br_out = 1'b0;
    int   br_len = 0;
    int   br_cnt = 0;
    int   br_phase = 0;
    int   rel_cyc = 0;
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    // released line floats to the asserted level
    assign flush_line = flush_oe ? flush_out : (br_oe ? br_out : 1'b1);

    bus_handoff_ctrl #(.NUM_MST(NUM_MST), .NUM_DMA(NUM_DMA), .ID_W(ID_W)) u_bus_handoff_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .arb_valid_i  (arb_valid),
        .arb_kind_i   (arb_kind),
        .arb_id_i     (arb_id),
        .bridge_req_i (bridge_req),
        .hold_o       (hold),
        .hold_ack_i   (hold_ack),
        .flush_oe_o   (flush_oe),
        .flush_out_o  (flush_out),
        .flush_in_i   (flush_line),
        .mst_ack_o    (mst_ack),
        .dma_ack_o    (dma_ack)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            br_oe <= 1'b0; br_out <= 1'b0; br_phase <= 0;
        end else begin
            case (br_phase)
                0: if (flush_oe && flush_out) begin
                       br_oe <= 1'b1; br_out <= 1'b1; br_cnt <= br_len; br_phase <= 1;
                   end
                1: if (br_cnt == 0) begin
                       br_out <= 1'b0; br_phase <= 2;
                   end else br_cnt <= br_cnt - 1;
                default: begin
                       br_oe <= 1'b0; br_phase <= 0; rel_cyc <= cyc + 1;
                   end
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // continuous line monitor: R11 overlap, R6 ack only after flush done
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (flush_oe && br_oe) chk(1'b0, "R11 driver overlap", 1, 0);
            if ((|mst_ack) || (|dma_ack))
                chk(flush_oe && !flush_out && !br_oe, "R6 ack before flush done",
                    int'(flush_line), 0);
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        step();
        chk(hold == 1'b0, "R1 hold in reset", int'(hold), 0);
        chk(flush_oe == 1'b1 && flush_out == 1'b0, "R1 flush drive in reset",
            int'({flush_oe, flush_out}), 2);
        chk(mst_ack == '0 && dma_ack == '0, "R1 acks in reset", int'({dma_ack, mst_ack}), 0);
        rst_n = 1'b1;
        step();
        chk(hold == 1'b0 && mst_ack == '0, "R1 after reset", int'(hold), 0);
    endtask

    // k0/i0 requested first, k1/i1 present on the freezing edge
    task automatic t_grant(input logic [1:0] k0, input int i0, input logic [1:0] k1,
                           input int i1, input int ack_dly, input int flen, input bit preempt);
        int exp_vec;
        int got_cyc;
        br_len = flen;
        arb_valid = 1'b1; arb_kind = k0; arb_id = ID_W'(i0);
        step();
        chk(hold == 1'b1, "R2 hold raised", int'(hold), 1);
        repeat (ack_dly) begin
            step();
            chk(hold && flush_oe && !flush_out && mst_ack == '0 && dma_ack == '0,
                "R3 waiting for ack", int'(hold), 1);
        end
        arb_kind = k1; arb_id = ID_W'(i1); hold_ack = 1'b1;
        step();
        chk(flush_oe && flush_out, "R5 flush pulse", int'({flush_oe, flush_out}), 3);
        arb_kind = 2'd1; arb_id = ID_W'(i1 + 1);   // must not alter the frozen winner (R3)
        step();
        chk(!flush_oe, "R5 line released", int'(flush_oe), 0);
        arb_kind = k1; arb_id = ID_W'(i1);
        got_cyc = -1;
        for (int n = 0; n < 100; n++) begin
            step();
            if ((|mst_ack) || (|dma_ack)) begin got_cyc = cyc; break; end
        end
        exp_vec = (k1 == 2'd1) ? (1 << i1) : (1 << (i1 + NUM_MST));
        chk(int'({dma_ack, mst_ack}) == exp_vec, "R3 R7 frozen winner ack",
            int'({dma_ack, mst_ack}), exp_vec);
        chk(got_cyc == rel_cyc + 1, "R6 R7 ack one cycle after resume", got_cyc, rel_cyc + 1);
        step();
        chk(int'({dma_ack, mst_ack}) == exp_vec && hold, "R8 ack steady",
            int'({dma_ack, mst_ack}), exp_vec);
        if (preempt) begin
            bridge_req = 1'b1;
            step();
            chk(!hold && mst_ack == '0 && dma_ack == '0, "R9 preempt drops ack and hold",
                int'({hold, dma_ack, mst_ack}), 0);
            bridge_req = 1'b0;
        end else begin
            arb_valid = 1'b0;
            step();
            chk(!hold && mst_ack == '0 && dma_ack == '0, "R8 withdraw drops ack and hold",
                int'({hold, dma_ack, mst_ack}), 0);
        end
        arb_valid = 1'b1; arb_kind = 2'd2; arb_id = '0;
        step(); step();
        chk(!hold, "R10 no hold while ack still high", int'(hold), 0);
        arb_valid = 1'b0; hold_ack = 1'b0;
        step(); step();
        chk(!hold, "R10 idle after release", int'(hold), 0);
    endtask

    task automatic t_bridge_winner();
        arb_valid = 1'b1; arb_kind = 2'd1; arb_id = 3'd4;
        step();
        chk(hold, "R2 hold raised", int'(hold), 1);
        arb_kind = 2'd3; hold_ack = 1'b1;   // kind 3 names the bridge
        step();
        chk(!hold, "R4 hold dropped for bridge winner", int'(hold), 1'b0);
        chk(flush_oe && !flush_out, "R4 no flush pulse", int'({flush_oe, flush_out}), 2);
        step();
        chk(mst_ack == '0 && dma_ack == '0 && flush_oe && !flush_out && !br_oe,
            "R4 no ack and no flush", int'({dma_ack, mst_ack}), 0);
        arb_valid = 1'b0; hold_ack = 1'b0;
        step(); step();
    endtask

    initial begin
        t_reset();
        t_grant(2'd1, 3, 2'd1, 3, 0, 0, 1'b0);
        t_grant(2'd2, 5, 2'd2, 5, 2, 3, 1'b0);
        t_grant(2'd1, 2, 2'd2, 6, 3, $urandom_range(0, 7), 1'b0);
        t_grant(2'd2, 1, 2'd1, 0, 1, $urandom_range(0, 7), 1'b1);
        t_grant(2'd1, 7, 2'd1, 6, 4, $urandom_range(0, 7), 1'b1);
        t_bridge_winner();
        for (int r = 0; r < 4; r++)
            t_grant(2'd1 + 2'(r % 2), r, 2'd2 - 2'(r % 2), r + 2,
                    $urandom_range(0, 4), $urandom_range(0, 9), r[0]);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "watchdog expired", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule